// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block puts a byte-wide memory array behind a two-wire serial bus in the I2C style. The slave responds to one 7-bit device address, accepts a 16-bit word address sent high byte first, and stores or returns data bytes one at a time or in bursts. The array sits inside the block. Its size is set by `ADDR_W`: the default is 11 bits (2 KiB), and 15 bits gives a 32 KiB array. Address bits above `ADDR_W` are dropped.

A single address latch is shared by reads and writes and survives from one transaction to the next. A read header with no address phase therefore continues from where the previous access stopped. A write header that carries only the two address bytes, followed by a repeated Start and a read header, performs a random read. The bus lines are sampled by the system clock through two-flop synchronizers. The slave only pulls SDA low through an open-drain enable, and it changes that enable only while SCL is low.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the address latch is 0. Memory contents are not cleared by reset, so a read header sent right after reset returns the byte stored at address 0.
- R2: The device byte is the 7-bit address `DEV_ADDR` (default 7'h50) in bits 7:1, followed by R/W in bit 0, where 1 means read. A matching device byte is acknowledged by holding SDA low through the 9th clock. A non-matching one is not acknowledged, and SDA stays released with no memory change until the next Start.
- R3: A write is: device byte with R/W=0, address high byte, address low byte, then data. Every byte is acknowledged. The data byte lands at `{high,low}` masked to `ADDR_W` bits, so 16'hF810 maps to 11'h010.
- R4: In a burst write, each further data byte goes to the address one above the previous byte.
- R5: A data byte is committed on the rising SCL edge of its 8th bit. A Start or Stop that arrives before that edge leaves memory unchanged.
- R6: A device byte with R/W=1 starts a read at the address latch. The latch holds the address just after the last byte written or read.
- R7: After each byte read, the latch increments. A master ACK (SDA low in the 9th clock) makes the slave send the next byte.
- R8: The latch wraps from the top address (2^ADDR_W - 1) to 0 on both reads and writes.
- R9: A selective read (write header with two address bytes, then a repeated Start and a read header) returns data starting at the given address.
- R10: A read ends cleanly in each of four cases: NACK then Stop, NACK then Start, Stop in the 9th clock, or Start in the 9th clock. SDA is released each time, and the next transaction continues from the correct address.
- R11: The slave starts or stops pulling SDA only while SCL is low. It never pulls SDA while the master owns the data line during SCL high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench checks the data it reads back against its own model of the memory and the latch. A wrong latch value therefore shows up as a wrong byte on the first read that follows, within one byte time (nine SCL periods). A wrong bit counter or phase shows up in two ways: an acknowledge missing from the 9th clock, or SDA driven while the master is sending. A per-clock ownership monitor catches the second case in the same SCL high period. A byte committed by mistake after an aborted write is exposed by the read-back of that location.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  // next location after an access, folded into the array size
  function automatic logic [15:0] addr_step(input logic [15:0] a,
                                            input logic [15:0] mask);
    return (a + 16'd1) & mask;
  endfunction

  // word address from the two header bytes, upper bits dropped
  function automatic logic [15:0] addr_fold(input logic [7:0] hi,
                                            input logic [7:0] lo,
                                            input logic [15:0] mask);
    return {hi, lo} & mask;
  endfunction

endpackage

// File: rtl/i2c_line_cond.sv
`timescale 1ns/1ps
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic scl_d, sda_d;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = ff[SYNC_STAGES-1];
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
`timescale 1ns/1ps
module i2c_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/i2c_mem_ctrl.sv
`timescale 1ns/1ps
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         ADDR_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe,
  output phase_t            phase,
  output logic [3:0]        bit_cnt,
  output logic [15:0]       addr_q
);

  localparam logic [15:0] AMASK = 16'((32'h1 << ADDR_W) - 32'h1);

  logic [7:0] shreg;
  logic [7:0] tx_sh;
  logic [7:0] ahi;
  logic [7:0] byte_in;
  logic       ack_go;
  logic       rd_mode;
  logic       rd_more;

  assign byte_in   = {shreg[6:0], sda_s};
  assign mem_we    = (phase == PH_WDATA) && scl_rise && (bit_cnt == 4'd7);
  assign mem_wdata = byte_in;
  assign mem_addr  = addr_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= 4'd0;
      shreg   <= 8'd0;
      tx_sh   <= 8'd0;
      ahi     <= 8'd0;
      addr_q  <= 16'd0;
      sda_oe  <= 1'b0;
      ack_go  <= 1'b0;
      rd_mode <= 1'b0;
      rd_more <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_DEV;
      bit_cnt <= 4'd0;
      sda_oe  <= 1'b0;
      ack_go  <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      bit_cnt <= 4'd0;
      sda_oe  <= 1'b0;
      ack_go  <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) begin
          shreg   <= byte_in;
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            case (phase)
              PH_DEV: begin
                if (shreg[6:0] == DEV_ADDR) begin
                  ack_go  <= 1'b1;
                  rd_mode <= sda_s;
                end else begin
                  phase   <= PH_IDLE;
                  bit_cnt <= 4'd0;
                end
              end
              PH_AHI: begin
                ahi    <= byte_in;
                ack_go <= 1'b1;
              end
              PH_ALO: begin
                addr_q <= addr_fold(ahi, byte_in, AMASK);
                ack_go <= 1'b1;
              end
              PH_WDATA: begin
                addr_q <= addr_step(addr_q, AMASK);
                ack_go <= 1'b1;
              end
              default: ack_go <= 1'b0;
            endcase
          end
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
          if (phase == PH_RDATA) rd_more <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (phase == PH_RDATA && bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
          sda_oe <= ~tx_sh[6];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end else if (bit_cnt == 4'd8) begin
          sda_oe <= ack_go;
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= 4'd0;
          ack_go  <= 1'b0;
          sda_oe  <= 1'b0;
          case (phase)
            PH_DEV: begin
              if (rd_mode) begin
                phase  <= PH_RDATA;
                tx_sh  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                addr_q <= addr_step(addr_q, AMASK);
              end else begin
                phase <= PH_AHI;
              end
            end
            PH_AHI: phase <= PH_ALO;
            PH_ALO: phase <= PH_WDATA;
            PH_RDATA: begin
              if (rd_more) begin
                tx_sh  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                addr_q <= addr_step(addr_q, AMASK);
              end else begin
                phase <= PH_IDLE;
              end
            end
            default: phase <= phase;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 11,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall;
  logic              start_evt, stop_evt;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  phase_t            phase;
  logic [3:0]        bit_cnt;
  logic [15:0]       addr_q;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mem_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sda_oe(sda_oe), .phase(phase),
    .bit_cnt(bit_cnt), .addr_q(addr_q)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

endmodule

// File: rtl/i2c_mem_checker.sv
`timescale 1ns/1ps
module i2c_mem_checker
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        sda_oe,
  input logic        mem_we,
  input phase_t      phase,
  input logic [3:0]  bit_cnt,
  input logic [15:0] addr_q
);

  localparam logic [15:0] AMASK = 16'((32'h1 << ADDR_W) - 32'h1);

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11

  AST_RELEASE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_s || $past(start_evt || stop_evt))); // R11

  AST_START_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && phase == PH_DEV)); // R10

  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && phase == PH_IDLE)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe); // R2

  AST_COMMIT_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (phase == PH_WDATA && bit_cnt == 4'd8)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == addr_step($past(addr_q), AMASK))); // R4

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~AMASK) == 16'd0); // R8

endmodule

bind i2c_mem_slave i2c_mem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .mem_we(mem_we),
  .phase(phase), .bit_cnt(bit_cnt), .addr_q(addr_q)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;

  localparam int Q     = 10;
  localparam int AMASK = 16'h07FF;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int mon_own = 0;
  int mon_high = 0;
  bit own_master = 1'b0;
  logic oe_prev = 1'b0;

  logic [7:0] ref_mem [2048];
  int ref_addr = 0;
  logic [7:0] wq [$];

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  // per-clock ownership model: master owns SDA while it sends, slave may only move while SCL low
  always @(negedge clk) begin
    if (own_master && sda_oe) mon_own++;
    if (rst_n && sda_oe && !oe_prev && scl) mon_high++;
    oe_prev <= sda_oe;
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; tick(Q);
    own_master = 1'b1;
    scl = 1'b1; tick(2 * Q);
    own_master = 1'b0;
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_bus;  tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv8(output logic [7:0] d);
    bit b;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      d = {d[6:0], b};
    end
  endtask

  // device byte, R2 acknowledge expected on a match
  task automatic header(bit rd, string req);
    bit ack;
    send_byte({DEV, rd}, ack);
    chk(req, "device byte acknowledged", ack, 1);
  endtask

  task automatic set_addr(logic [15:0] a, string req);
    bit ack;
    bus_start();
    header(1'b0, req);
    send_byte(a[15:8], ack); chk(req, "address high acked", ack, 1);
    send_byte(a[7:0], ack);  chk(req, "address low acked", ack, 1);
    ref_addr = a & AMASK;
  endtask

  // write the queued bytes starting at address a
  task automatic write_seq(logic [15:0] a, string req);
    bit ack;
    set_addr(a, req);
    foreach (wq[k]) begin
      send_byte(wq[k], ack);
      chk(req, "data byte acked", ack, 1);
      ref_mem[ref_addr] = wq[k];
      ref_addr = (ref_addr + 1) & AMASK;
    end
    bus_stop();
    wq.delete();
  endtask

  // read one byte and compare with the model at the latch
  task automatic read_one(string req);
    logic [7:0] d;
    recv8(d);
    chk(req, $sformatf("read at %0h", ref_addr), d, ref_mem[ref_addr]);
    ref_addr = (ref_addr + 1) & AMASK;
  endtask

  // read n bytes after a start, ACK all but the last, NACK then stop
  task automatic read_n(int n, string req);
    header(1'b1, req);
    for (int k = 0; k < n; k++) begin
      read_one(req);
      send_bit(k == n - 1);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    tick(5);
    chk("R1", "sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "sda_oe after reset", sda_oe, 0);

    // R3 single write at 0, then reset clears the latch but not memory
    wq.push_back(8'hA5);
    write_seq(16'h0000, "R3");
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    ref_addr = 0;
    bus_start();
    read_n(1, "R1");

    // R6 latch follows the last written byte
    wq.push_back(8'h9C);
    write_seq(16'h0301, "R3");
    wq.push_back(8'h10);
    write_seq(16'h0300, "R3");
    bus_start();
    read_n(1, "R6");

    // R3 upper address bits are dropped: F810 -> 010
    wq.push_back(8'h3C);
    write_seq(16'hF810, "R3");
    set_addr(16'h0010, "R9");
    bus_start();
    read_n(1, "R3");

    // R4 burst write, R9 selective read, R7 sequential read
    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    write_seq(16'h0123, "R4");
    set_addr(16'h0123, "R9");
    bus_start();
    read_n(3, "R7");
    bus_start();
    read_n(1, "R6");

    // R8 wrap on write and read
    wq = '{8'hE1, 8'hE2};
    write_seq(16'h07FF, "R8");
    set_addr(16'h07FF, "R8");
    bus_start();
    read_n(2, "R8");

    // R10 four read terminations
    set_addr(16'h0123, "R10");
    bus_start();
    read_n(1, "R10");                       // NACK then stop
    chk("R10", "released after NACK+stop", sda_oe, 0);
    bus_start();
    header(1'b1, "R10");
    read_one("R10");
    send_bit(1'b1);                         // NACK then start
    bus_start();
    chk("R10", "released after NACK+start", sda_oe, 0);
    header(1'b1, "R10");
    read_one("R10");
    send_bit(1'b1);
    bus_stop();
    bus_start();
    header(1'b1, "R10");
    read_one("R10");
    bus_stop();                             // stop in 9th slot
    chk("R10", "released after stop in 9th clock", sda_oe, 0);
    bus_start();
    header(1'b1, "R10");
    read_one("R10");
    bus_start();                            // start in 9th slot
    chk("R10", "released after start in 9th clock", sda_oe, 0);
    header(1'b1, "R10");
    read_one("R10");
    send_bit(1'b1);
    bus_stop();

    // R5 aborted data bytes leave memory unchanged
    wq.push_back(8'h81);
    write_seq(16'h0040, "R5");
    set_addr(16'h0040, "R5");
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_start();
    bus_stop();
    set_addr(16'h0040, "R5");
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    bus_stop();
    set_addr(16'h0040, "R5");
    bus_start();
    read_n(1, "R5");

    // R2 mismatched device address: no ack, no write
    bus_start();
    send_byte({7'h51, 1'b0}, ack);
    chk("R2", "mismatch device not acked", ack, 0);
    send_byte(8'h00, ack); chk("R2", "ignored byte not acked", ack, 0);
    send_byte(8'h40, ack); chk("R2", "ignored byte not acked", ack, 0);
    send_byte(8'h00, ack); chk("R2", "ignored byte not acked", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h51, 1'b1}, ack);
    chk("R2", "mismatch read not acked", ack, 0);
    bus_stop();
    set_addr(16'h0040, "R2");
    bus_start();
    read_n(1, "R2");

    tick(10);
    chk("R11", "slave drove SDA while master owned it", mon_own, 0);
    chk("R11", "slave started driving while SCL high", mon_high, 0);
    finish_up();
  end

endmodule